// File: doc/BRIEF.md
# Three-Phase Commutation and Protection Controller

This block turns three Hall sensor bits into the six gate enables of a three-phase brushless motor bridge. Each phase has an upper and a lower enable. A six-step table picks which upper and which lower switch conduct for each rotor position, and the direction input selects the forward table or its mirror. Direction may be changed at any moment, even while the rotor turns. The PWM carrier chops only the upper enables during normal drive. The lower enables stay steady.

Several conditions override normal drive. In order of precedence they are: an active fault input (thermal or supply), a stop request, a latched lock-protection trip, and short braking. A slow tick advances a hold counter while the speed-lock indicator reports loss of lock. When the count reaches a programmable limit, the upper side is shut off and stays off until the motor is stopped. This protection can be switched off. Whenever the selected drive pattern changes, the bridge is blanked for a programmable number of clocks, so the two switches of one phase are never on together.

Top module: `bldc_commutator`

## Requirements
- R1: In normal drive with direction forward (`dir_rev_i`=0) and `pwm_i`=1, Hall codes map to (upper, lower) enables as follows, where enable bit 0 is phase U, bit 1 is V and bit 2 is W: 001→(001,010), 011→(001,100), 010→(010,100), 110→(010,001), 100→(100,001), 101→(100,010).
- R2: With `dir_rev_i`=1, the upper and lower enables of the R1 table are swapped for every valid Hall code.
- R3: Hall codes 000 and 111 turn all six enables off whenever braking is not requested.
- R4: In normal drive the upper enables equal the table value ANDed with `pwm_i`. The lower enables ignore `pwm_i`. When braking is not requested, a low `pwm_i` leaves all upper enables off.
- R5: With `brake_i`=1, and no fault, stop or trip present, the upper enables are 111 and the lower enables are 000, regardless of the Hall code and `pwm_i`.
- R6: With `stop_i`=1 all enables are off, even while braking is requested.
- R7: Any bit of `fault_i` set turns all enables off, overriding every other input.
- R8: With `hold_en_i`=1, when `hold_limit_i` ticks are counted on `tick_i` while `lock_lost_i` stays high, the block trips. While tripped, the upper enables are off and the lower enables follow the table, even if braking is requested.
- R9: A low level on `lock_lost_i` clears the hold count, so interrupted periods of lock loss do not add up toward a trip.
- R10: A trip stays latched after `lock_lost_i` returns low. It is cleared only by `stop_i`=1, by `hold_en_i`=0, or by reset.
- R11: With `hold_en_i`=0, no number of ticks under lock loss produces a trip.
- R12: When the selected pattern changes, all enables are off for `dead_i`+1 clocks before the new pattern appears. An upper and a lower enable of the same phase are never on together.
- R13: While `rst` is high, all enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_i | input | 3 | Hall sensor code |
| dir_rev_i | input | 1 | 0 forward, 1 reverse |
| brake_i | input | 1 | 1 requests short braking |
| stop_i | input | 1 | 1 stops the motor and clears a trip |
| pwm_i | input | 1 | PWM carrier for the upper side |
| lock_lost_i | input | 1 | 1 when speed is out of lock |
| tick_i | input | 1 | Slow time base pulse for the hold counter |
| hold_en_i | input | 1 | 1 enables lock protection |
| hold_limit_i | input | HOLD_W | Number of ticks that causes a trip |
| dead_i | input | DEAD_W | Blanking clocks on a pattern change |
| fault_i | input | FAULT_N | Fault inputs, active high |
| hi_o | output | 3 | Upper enables, bit 0 U, bit 1 V, bit 2 W |
| lo_o | output | 3 | Lower enables, same bit order |

## Verification
A wrong hold count or trip latch shows at the ports only under certain conditions. A trip that fires early or late moves the moment the upper enables go dark by whole ticks. A latch that fails to hold shows as drive coming back as soon as lock loss ends. A stale internal pattern or a blanking counter that does not reload shows within `dead_i`+2 clocks of a Hall or direction change, as a missing blank or a direct jump between two lower patterns. Any overlap of the upper and lower enables of one phase shows in the very clock it happens.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  localparam int PHASES = 3;

  typedef struct packed {
    logic [PHASES-1:0] hi;
    logic [PHASES-1:0] lo;
    logic              chop;
  } drive_t;

  localparam drive_t DRIVE_OFF = '{hi: '0, lo: '0, chop: 1'b0};
endpackage

// File: rtl/bldc_step_decode.sv
module bldc_step_decode
  import bldc_pkg::*;
(
  input  logic [PHASES-1:0] hall,
  input  logic              rev,
  output logic [PHASES-1:0] hi,
  output logic [PHASES-1:0] lo
);
  logic [PHASES-1:0] fwd_hi, fwd_lo;

  always_comb begin
    unique case (hall)
      3'b001:  begin fwd_hi = 3'b001; fwd_lo = 3'b010; end
      3'b011:  begin fwd_hi = 3'b001; fwd_lo = 3'b100; end
      3'b010:  begin fwd_hi = 3'b010; fwd_lo = 3'b100; end
      3'b110:  begin fwd_hi = 3'b010; fwd_lo = 3'b001; end
      3'b100:  begin fwd_hi = 3'b100; fwd_lo = 3'b001; end
      3'b101:  begin fwd_hi = 3'b100; fwd_lo = 3'b010; end
      default: begin fwd_hi = 3'b000; fwd_lo = 3'b000; end
    endcase
  end

  // Reverse drives the complementary current: swap the sides.
  assign hi = rev ? fwd_lo : fwd_hi;
  assign lo = rev ? fwd_hi : fwd_lo;
endmodule

// File: rtl/bldc_hold_timer.sv
module bldc_hold_timer #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              lost,
  input  logic              en,
  input  logic              stop,
  input  logic [HOLD_W-1:0] limit,
  output logic              tripped
);
  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      tripped <= 1'b0;
    end else if (stop || !en) begin
      cnt_q   <= '0;
      tripped <= 1'b0;
    end else if (!lost) begin
      cnt_q <= '0;
    end else if (tick && !tripped) begin
      if (cnt_inc >= {1'b0, limit}) tripped <= 1'b1;
      else                          cnt_q   <= cnt_inc[HOLD_W-1:0];
    end
  end
endmodule

// File: rtl/bldc_gate_out.sv
module bldc_gate_out
  import bldc_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  drive_t            want,
  input  logic              pwm,
  input  logic [DEAD_W-1:0] dead,
  output logic [PHASES-1:0] hi_o,
  output logic [PHASES-1:0] lo_o
);
  drive_t            pat_q;
  logic [DEAD_W-1:0] cnt_q;
  logic              changed, settled;
  logic [PHASES-1:0] hi_next;

  assign changed = (want != pat_q);
  assign settled = !changed && (cnt_q == '0);

  for (genvar p = 0; p < PHASES; p++) begin : g_chop
    assign hi_next[p] = want.hi[p] & (pwm | ~want.chop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q <= DRIVE_OFF;
      cnt_q <= '0;
      hi_o  <= '0;
      lo_o  <= '0;
    end else begin
      pat_q <= want;
      if (changed)            cnt_q <= dead;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      hi_o <= settled ? hi_next : '0;
      lo_o <= settled ? want.lo : '0;
    end
  end
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_pkg::*;
#(
  parameter int HOLD_W  = 16,
  parameter int DEAD_W  = 8,
  parameter int FAULT_N = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         hall_i,
  input  logic               dir_rev_i,
  input  logic               brake_i,
  input  logic               stop_i,
  input  logic               pwm_i,
  input  logic               lock_lost_i,
  input  logic               tick_i,
  input  logic               hold_en_i,
  input  logic [HOLD_W-1:0]  hold_limit_i,
  input  logic [DEAD_W-1:0]  dead_i,
  input  logic [FAULT_N-1:0] fault_i,
  output logic [2:0]         hi_o,
  output logic [2:0]         lo_o
);
  logic [PHASES-1:0] tab_hi, tab_lo;
  logic              tripped;
  drive_t            want;

  bldc_step_decode u_step (
    .hall (hall_i),
    .rev  (dir_rev_i),
    .hi   (tab_hi),
    .lo   (tab_lo)
  );

  bldc_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_i),
    .lost    (lock_lost_i),
    .en      (hold_en_i),
    .stop    (stop_i),
    .limit   (hold_limit_i),
    .tripped (tripped)
  );

  // Precedence: fault, stop, trip, brake, normal drive.
  always_comb begin
    want = DRIVE_OFF;
    if (|fault_i || stop_i) begin
      want = DRIVE_OFF;
    end else if (tripped) begin
      want.lo = tab_lo;
    end else if (brake_i) begin
      want.hi = '1;
    end else begin
      want.hi   = tab_hi;
      want.lo   = tab_lo;
      want.chop = 1'b1;
    end
  end

  bldc_gate_out #(.DEAD_W(DEAD_W)) u_gate (
    .clk  (clk),
    .rst  (rst),
    .want (want),
    .pwm  (pwm_i),
    .dead (dead_i),
    .hi_o (hi_o),
    .lo_o (lo_o)
  );
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk #(
  parameter int FAULT_N = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         hall_i,
  input logic               brake_i,
  input logic               stop_i,
  input logic               pwm_i,
  input logic [FAULT_N-1:0] fault_i,
  input logic [2:0]         hi_o,
  input logic [2:0]         lo_o
);
  p_no_overlap_r12: assert property (@(posedge clk) disable iff (rst)
    (hi_o & lo_o) == 3'b000);

  p_lo_gap_r12: assert property (@(posedge clk) disable iff (rst)
    (lo_o != 3'b000 && $past(lo_o) != 3'b000) |-> lo_o == $past(lo_o));

  p_fault_off_r7: assert property (@(posedge clk) disable iff (rst)
    (|fault_i) |=> (hi_o == 3'b000 && lo_o == 3'b000));

  p_stop_off_r6: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (hi_o == 3'b000 && lo_o == 3'b000));

  p_invalid_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!brake_i && (hall_i == 3'b000 || hall_i == 3'b111)) |=> (hi_o == 3'b000 && lo_o == 3'b000));

  p_pwm_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!brake_i && !pwm_i) |=> hi_o == 3'b000);

  p_reset_off_r13: assert property (@(posedge clk)
    rst |=> (hi_o == 3'b000 && lo_o == 3'b000));
endmodule

bind bldc_commutator bldc_commutator_chk #(.FAULT_N(FAULT_N)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .hall_i  (hall_i),
  .brake_i (brake_i),
  .stop_i  (stop_i),
  .pwm_i   (pwm_i),
  .fault_i (fault_i),
  .hi_o    (hi_o),
  .lo_o    (lo_o)
);

// File: tb/bldc_commutator_tb_top.sv
module bldc_commutator_tb_top;
  localparam int HOLD_W  = 16;
  localparam int DEAD_W  = 8;
  localparam int FAULT_N = 2;
  localparam int NVEC    = 22;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [2:0]         hall_i = 3'b000;
  logic               dir_rev_i = 1'b0;
  logic               brake_i = 1'b0;
  logic               stop_i = 1'b0;
  logic               pwm_i = 1'b1;
  logic               lock_lost_i = 1'b0;
  logic               tick_i = 1'b0;
  logic               hold_en_i = 1'b0;
  logic [HOLD_W-1:0]  hold_limit_i = 16'd4;
  logic [DEAD_W-1:0]  dead_i = 8'd2;
  logic [FAULT_N-1:0] fault_i = '0;
  logic [2:0]         hi_o, lo_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bldc_commutator #(.HOLD_W(HOLD_W), .DEAD_W(DEAD_W), .FAULT_N(FAULT_N)) dut_i (
    .clk(clk), .rst(rst), .hall_i(hall_i), .dir_rev_i(dir_rev_i),
    .brake_i(brake_i), .stop_i(stop_i), .pwm_i(pwm_i),
    .lock_lost_i(lock_lost_i), .tick_i(tick_i), .hold_en_i(hold_en_i),
    .hold_limit_i(hold_limit_i), .dead_i(dead_i), .fault_i(fault_i),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  // hall, rev, brake, stop, pwm, fault[1:0], exp_hi, exp_lo
  localparam logic [14:0] VEC [0:NVEC-1] = '{
    15'b001_0_0_0_1_00_001_010,  // R1
    15'b011_0_0_0_1_00_001_100,  // R1
    15'b010_0_0_0_1_00_010_100,  // R1
    15'b110_0_0_0_1_00_010_001,  // R1
    15'b100_0_0_0_1_00_100_001,  // R1
    15'b101_0_0_0_1_00_100_010,  // R1
    15'b001_1_0_0_1_00_010_001,  // R2
    15'b011_1_0_0_1_00_100_001,  // R2
    15'b010_1_0_0_1_00_100_010,  // R2
    15'b110_1_0_0_1_00_001_010,  // R2
    15'b100_1_0_0_1_00_001_100,  // R2
    15'b101_1_0_0_1_00_010_100,  // R2
    15'b000_0_0_0_1_00_000_000,  // R3
    15'b111_1_0_0_1_00_000_000,  // R3
    15'b001_0_0_0_0_00_000_010,  // R4
    15'b110_1_0_0_0_00_000_010,  // R4
    15'b011_0_1_0_0_00_111_000,  // R5
    15'b111_0_1_0_1_00_111_000,  // R5
    15'b010_0_1_1_1_00_000_000,  // R6
    15'b100_0_0_1_1_00_000_000,  // R6
    15'b101_0_0_0_1_01_000_000,  // R7
    15'b011_0_1_0_1_10_000_000   // R7
  };

  function automatic string vec_tag(input logic [14:0] v);
    if (v[7:6] != 2'b00)                 return "R7";
    if (v[9])                            return "R6";
    if (v[10])                           return "R5";
    if (v[14:12] == 3'b000 || v[14:12] == 3'b111) return "R3";
    if (!v[8])                           return "R4";
    if (v[11])                           return "R2";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [2:0] eh, input logic [2:0] el);
    n_cmp++;
    if (hi_o !== eh || lo_o !== el) begin
      n_bad++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, hi_o, lo_o, eh, el);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic set_run(input logic [2:0] h);
    hall_i = h; dir_rev_i = 1'b0; brake_i = 1'b0; stop_i = 1'b0;
    pwm_i = 1'b1; fault_i = '0;
  endtask

  initial begin
    wait_clk(3);
    check("R13", 3'b000, 3'b000);
    @(negedge clk) rst = 1'b0;

    // Table walk
    for (int k = 0; k < NVEC; k++) begin
      hall_i    = VEC[k][14:12];
      dir_rev_i = VEC[k][11];
      brake_i   = VEC[k][10];
      stop_i    = VEC[k][9];
      pwm_i     = VEC[k][8];
      fault_i   = VEC[k][7:6];
      wait_clk(int'(dead_i) + 3);
      check(vec_tag(VEC[k]), VEC[k][5:3], VEC[k][2:0]);
    end

    // R12: blanking length with dead time 3, then 0
    dead_i = 8'd3;
    set_run(3'b001);
    wait_clk(8);
    check("R12", 3'b001, 3'b010);
    hall_i = 3'b011;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R12", 3'b000, 3'b000);
    end
    @(negedge clk);
    check("R12", 3'b001, 3'b100);
    dead_i = 8'd0;
    wait_clk(2);
    dir_rev_i = 1'b1;
    @(negedge clk);
    check("R12", 3'b000, 3'b000);
    @(negedge clk);
    check("R12", 3'b100, 3'b001);

    // R8: trip after the fourth tick of continuous lock loss
    dead_i = 8'd2;
    set_run(3'b001);
    hold_limit_i = 16'd4;
    hold_en_i = 1'b1;
    lock_lost_i = 1'b1;
    wait_clk(5);
    for (int k = 0; k < 3; k++) pulse_tick();
    wait_clk(5);
    check("R8", 3'b001, 3'b010);
    pulse_tick();
    wait_clk(5);
    check("R8", 3'b000, 3'b010);
    brake_i = 1'b1;
    wait_clk(5);
    check("R8", 3'b000, 3'b010);
    brake_i = 1'b0;

    // R10: latch holds after lock returns, stop clears it
    lock_lost_i = 1'b0;
    wait_clk(5);
    check("R10", 3'b000, 3'b010);
    stop_i = 1'b1;
    wait_clk(3);
    stop_i = 1'b0;
    wait_clk(5);
    check("R10", 3'b001, 3'b010);

    // R9: interrupted loss does not accumulate
    lock_lost_i = 1'b1;
    for (int k = 0; k < 3; k++) pulse_tick();
    @(negedge clk) lock_lost_i = 1'b0;
    @(negedge clk) lock_lost_i = 1'b1;
    for (int k = 0; k < 3; k++) pulse_tick();
    wait_clk(5);
    check("R9", 3'b001, 3'b010);
    lock_lost_i = 1'b0;
    wait_clk(2);

    // R11: disabled protection never trips
    hold_en_i = 1'b0;
    lock_lost_i = 1'b1;
    for (int k = 0; k < 10; k++) pulse_tick();
    wait_clk(5);
    check("R11", 3'b001, 3'b010);
    lock_lost_i = 1'b0;

    // R13: reset mid-run turns everything off
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R13", 3'b000, 3'b000);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule